// File: doc/BRIEF.md
# Flash Two-Cycle Command Sequencer

This block sits between a CPU-side bus and an on-chip flash array. Software drives it purely with bus writes: a first write carries a command code in the low data byte, and for commands that need more, a second write carries a confirm code and/or an address that selects an array block. The sequencer decodes these writes and picks what later bus reads return: array words, a status byte, or the lock bit of one block. It also launches the long-running operations, which are a whole-array erase and the locking of a single block.

The flash back end is a behavioral model. Each block has a "blank" flag and a lock bit. A word that has not been erased reads as its address XOR 0xA5, and an erased word reads as all ones. Operation length is a countdown of `OP_CYCLES` clock cycles. The block index is the top `log2(NUM_BLOCKS)` address bits; with the defaults these are addr[7:6], giving 64 words per block.

The state machine has these states: `S_IDLE`, which accepts first-cycle codes; `S_ERASE_CFM` and `S_LOCK_CFM`, which wait for the confirm write; `S_LOCK_ADDR`, which waits for the address write of a lock-bit read; and `S_ERASE_RUN` and `S_LOCK_RUN`, which are the busy states. The transitions are as follows. `S_IDLE` goes to `S_ERASE_CFM` on 0xA7, to `S_LOCK_CFM` on 0x77 and to `S_LOCK_ADDR` on 0x71. Each confirm state goes to its run state on 0xD0 and back to `S_IDLE` on any other code, which counts as a bad confirm. `S_LOCK_ADDR` goes to `S_IDLE` on any write. `S_ERASE_RUN` steps through the blocks and goes to `S_IDLE` after the last one. `S_LOCK_RUN` goes to `S_IDLE` when its timer expires.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset `ready` is 1, reads return array words (address XOR 0xA5), the status byte is 0x80 and every block's lock bit is 1 (unlocked).
- R2: A write of 0xA7 followed by a write of 0xD0 erases the blocks one after another, starting at block 0. Each unlocked block holds `ready` low for `OP_CYCLES` cycles, so an all-unlocked array is busy for NUM_BLOCKS*OP_CYCLES cycles. Every word of an erased block then reads as all ones.
- R3: During erase-all, a block whose lock bit is 0 is passed over in a single cycle and keeps its contents.
- R4: A write of 0x77 followed by a write of 0xD0 holds `ready` low for exactly `OP_CYCLES` cycles. It then clears to 0 the lock bit of the block selected by the second write's address.
- R5: A write of 0x71 followed by any write latches the block selected by the second write's address. Reads then return that block's lock bit on data bit 6 (1 = unlocked, 0 = locked), with all other bits 0.
- R6: A write of 0x70 makes reads return the status byte: bit 7 is ready, bit 5 is the erase error, bit 4 is the program error and the other bits are 0.
- R7: A write of 0x50 clears status bits 5 and 4 and leaves the read mode unchanged.
- R8: While `ready` is 0, every bus write is ignored, including clear-status, and reads return the status byte whatever the read mode is.
- R9: If the second write of an erase-all or lock-program sequence is not 0xD0, the sequence is abandoned. Both error bits are set, no operation starts and reads return to array mode.
- R10: A first-cycle code that is not recognized (for example 0xFF) puts reads in array mode.
- R11: Launching an erase or lock-program selects status reads, and that mode remains after completion. `rdata` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle it is high |
| addr | input | ADDR_W | Bus address for reads and writes |
| wdata | input | DATA_W | Bus write data; low byte holds the command code |
| rd_en | input | 1 | Bus read strobe |
| rdata | output | DATA_W | Read data, selected by the read mode |
| ready | output | 1 | 1 when no automatic operation is running |

## Verification
The bench counts busy cycles exactly. A design that spent a full timer period on a locked block, or that let a lock-program run a cycle short or long, would give 49, 64 or 16 cycles in the wrong places. It writes clear-status and a mode change during an erase and then reads the status. A design that accepted writes while busy would lose the error bits or leave status mode. Bad confirm codes are sent for both two-cycle commands, and the bench then confirms that the lock bit is untouched and that array reads resume. A sequencer that treated any second write as a confirm would lock the block instead.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ERASE_CFM,
        S_LOCK_CFM,
        S_LOCK_ADDR,
        S_ERASE_RUN,
        S_LOCK_RUN
    } seq_state_t;

    typedef enum logic [1:0] {
        RD_ARRAY,
        RD_STATUS,
        RD_LOCK
    } rd_mode_t;

    localparam logic [7:0] CMD_ERASE_ALL = 8'hA7;
    localparam logic [7:0] CMD_LOCK_PGM  = 8'h77;
    localparam logic [7:0] CMD_LOCK_READ = 8'h71;
    localparam logic [7:0] CMD_READ_STAT = 8'h70;
    localparam logic [7:0] CMD_CLR_STAT  = 8'h50;
    localparam logic [7:0] CMD_CONFIRM   = 8'hD0;

endpackage

// File: rtl/fseq_op_timer.sv
module fseq_op_timer #(
    parameter int OP_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic last
);
    localparam int CW = $clog2(OP_CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(OP_CYCLES);
        end else if (tick && cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign last = (cnt == CW'(1));

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt) <= OP_CYCLES));

endmodule

// File: rtl/fseq_array_model.sv
module fseq_array_model #(
    parameter int          ADDR_W     = 8,
    parameter int          DATA_W     = 8,
    parameter int          NUM_BLOCKS = 4,
    parameter int          BLK_W      = 2,
    parameter logic [7:0]  FILL_KEY   = 8'hA5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  erase_stb,
    input  logic                  lock_stb,
    input  logic [BLK_W-1:0]      op_blk,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]     rd_word,
    output logic [NUM_BLOCKS-1:0] lock_vec
);
    logic [NUM_BLOCKS-1:0] blank;
    logic [BLK_W-1:0]      rd_blk;

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                blank[b]    <= 1'b0;
                lock_vec[b] <= 1'b1;
            end else begin
                if (erase_stb && op_blk == BLK_W'(b)) blank[b] <= 1'b1;
                if (lock_stb && op_blk == BLK_W'(b))  lock_vec[b] <= 1'b0;
            end
        end
    end

    assign rd_blk  = rd_addr[ADDR_W-1 -: BLK_W];
    assign rd_word = blank[rd_blk] ? '1 : (DATA_W'(rd_addr) ^ DATA_W'(FILL_KEY));

    // R4
    lock_never_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lock_vec & ~$past(lock_vec)) == '0));

    // R2
    blank_never_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~blank & $past(blank)) == '0));

    // R3
    erase_unlocked_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_stb |-> lock_vec[op_blk]);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int NUM_BLOCKS = 4,
    parameter int OP_CYCLES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic              ready
);
    import fseq_pkg::*;

    localparam int               BLK_W    = $clog2(NUM_BLOCKS);
    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

    seq_state_t state, nxt_state;
    rd_mode_t   mode, nxt_mode;

    logic             erase_err, prog_err;
    logic [BLK_W-1:0] blk_idx, lk_blk, wr_blk;
    logic [7:0]       code, status8;

    logic tmr_load, tmr_tick, tmr_last;
    logic erase_stb, lock_stb;
    logic start_erase, cap_blk, cap_lk, blk_inc;
    logic set_err, clr_err;

    logic [DATA_W-1:0]     rd_word;
    logic [NUM_BLOCKS-1:0] lock_vec;

    assign code    = wdata[7:0];
    assign wr_blk  = addr[ADDR_W-1 -: BLK_W];
    assign ready   = !(state == S_ERASE_RUN || state == S_LOCK_RUN);
    assign status8 = {ready, 1'b0, erase_err, prog_err, 4'b0000};

    fseq_op_timer #(.OP_CYCLES(OP_CYCLES)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .tick  (tmr_tick),
        .last  (tmr_last)
    );

    fseq_array_model #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLK_W      (BLK_W)
    ) array_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_stb (erase_stb),
        .lock_stb  (lock_stb),
        .op_blk    (blk_idx),
        .rd_addr   (addr),
        .rd_word   (rd_word),
        .lock_vec  (lock_vec)
    );

    // next state and control strobes
    always_comb begin
        nxt_state   = state;
        nxt_mode    = mode;
        tmr_load    = 1'b0;
        tmr_tick    = 1'b0;
        erase_stb   = 1'b0;
        lock_stb    = 1'b0;
        start_erase = 1'b0;
        cap_blk     = 1'b0;
        cap_lk      = 1'b0;
        blk_inc     = 1'b0;
        set_err     = 1'b0;
        clr_err     = 1'b0;
        unique case (state)
            S_IDLE: if (wr_en) begin
                case (code)
                    CMD_ERASE_ALL: nxt_state = S_ERASE_CFM;
                    CMD_LOCK_PGM:  nxt_state = S_LOCK_CFM;
                    CMD_LOCK_READ: nxt_state = S_LOCK_ADDR;
                    CMD_READ_STAT: nxt_mode  = RD_STATUS;
                    CMD_CLR_STAT:  clr_err   = 1'b1;
                    default:       nxt_mode  = RD_ARRAY;
                endcase
            end
            S_ERASE_CFM: if (wr_en) begin
                if (code == CMD_CONFIRM) begin
                    nxt_state   = S_ERASE_RUN;
                    nxt_mode    = RD_STATUS;
                    start_erase = 1'b1;
                    tmr_load    = 1'b1;
                end else begin
                    nxt_state = S_IDLE;
                    nxt_mode  = RD_ARRAY;
                    set_err   = 1'b1;
                end
            end
            S_LOCK_CFM: if (wr_en) begin
                if (code == CMD_CONFIRM) begin
                    nxt_state = S_LOCK_RUN;
                    nxt_mode  = RD_STATUS;
                    cap_blk   = 1'b1;
                    tmr_load  = 1'b1;
                end else begin
                    nxt_state = S_IDLE;
                    nxt_mode  = RD_ARRAY;
                    set_err   = 1'b1;
                end
            end
            S_LOCK_ADDR: if (wr_en) begin
                nxt_state = S_IDLE;
                nxt_mode  = RD_LOCK;
                cap_lk    = 1'b1;
            end
            S_ERASE_RUN: begin
                if (!lock_vec[blk_idx] || tmr_last) begin
                    erase_stb = lock_vec[blk_idx];
                    if (blk_idx == LAST_BLK) begin
                        nxt_state = S_IDLE;
                    end else begin
                        blk_inc  = 1'b1;
                        tmr_load = 1'b1;
                    end
                end else begin
                    tmr_tick = 1'b1;
                end
            end
            S_LOCK_RUN: begin
                tmr_tick = 1'b1;
                if (tmr_last) begin
                    lock_stb  = 1'b1;
                    nxt_state = S_IDLE;
                end
            end
            default: nxt_state = S_IDLE;
        endcase
    end

    // state register and sequencer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            mode      <= RD_ARRAY;
            erase_err <= 1'b0;
            prog_err  <= 1'b0;
            blk_idx   <= '0;
            lk_blk    <= '0;
        end else begin
            state <= nxt_state;
            mode  <= nxt_mode;
            if (set_err) begin
                erase_err <= 1'b1;
                prog_err  <= 1'b1;
            end else if (clr_err) begin
                erase_err <= 1'b0;
                prog_err  <= 1'b0;
            end
            if (start_erase)  blk_idx <= '0;
            else if (cap_blk) blk_idx <= wr_blk;
            else if (blk_inc) blk_idx <= blk_idx + BLK_W'(1);
            if (cap_lk) lk_blk <= wr_blk;
        end
    end

    // read data
    always_comb begin
        if (!rd_en) begin
            rdata = '0;
        end else if (!ready) begin
            rdata = DATA_W'(status8);
        end else begin
            case (mode)
                RD_ARRAY:  rdata = rd_word;
                RD_STATUS: rdata = DATA_W'(status8);
                RD_LOCK:   rdata = DATA_W'({1'b0, lock_vec[lk_blk], 6'b000000});
                default:   rdata = '0;
            endcase
        end
    end

    // R9
    bad_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_ERASE_CFM || state == S_LOCK_CFM) && wr_en && code != CMD_CONFIRM)
        |=> (erase_err && prog_err && mode == RD_ARRAY && ready));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ($stable(erase_err) && $stable(prog_err) && $stable(mode)));

    // R2
    erase_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ERASE_CFM && wr_en && code == CMD_CONFIRM)
        |=> (!ready && blk_idx == '0 && mode == RD_STATUS));

    // R4
    lock_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOCK_RUN && tmr_last) |=> (ready && !lock_vec[$past(blk_idx)]));

endmodule

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int OPC        = 16;
    localparam int NBLK       = 4;

    typedef struct packed {
        logic [7:0] d1;
        logic       two;
        logic [7:0] a2;
        logic [7:0] d2;
        logic [7:0] ra;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{8'h70, 1'b0, 8'h00, 8'h00, 8'h00, 8'h80, 4'd6},   // R6 status read
        '{8'hFF, 1'b0, 8'h00, 8'h00, 8'h10, 8'hB5, 4'd10},  // R10 back to array
        '{8'h71, 1'b1, 8'h7E, 8'h00, 8'h00, 8'h40, 4'd5},   // R5 block 1 unlocked
        '{8'h3C, 1'b0, 8'h00, 8'h00, 8'hC1, 8'h64, 4'd10},  // R10 unknown code
        '{8'hA7, 1'b1, 8'h00, 8'h11, 8'h05, 8'hA0, 4'd9},   // R9 bad erase confirm
        '{8'h70, 1'b0, 8'h00, 8'h00, 8'h00, 8'hB0, 4'd9},   // R9 both error bits
        '{8'h50, 1'b0, 8'h00, 8'h00, 8'h00, 8'h80, 4'd7},   // R7 clear, stays status
        '{8'h77, 1'b1, 8'h3E, 8'h99, 8'h3E, 8'h9B, 4'd9},   // R9 bad lock confirm
        '{8'h50, 1'b0, 8'h00, 8'h00, 8'h01, 8'hA4, 4'd7},   // R7 clear, stays array
        '{8'h71, 1'b1, 8'h3E, 8'h00, 8'h00, 8'h40, 4'd5}    // R5 block 0 still unlocked
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ready;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_cmd_seq #(
        .ADDR_W(8), .DATA_W(8), .NUM_BLOCKS(NBLK), .OP_CYCLES(OPC)
    ) dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rd_en (rd_en),
        .rdata (rdata),
        .ready (ready)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] v);
        rd_en = 1'b1;
        addr  = a;
        #1;
        v     = rdata;
        rd_en = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (!ready && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int         n;

        do_reset();
        // R1 reset state
        check("R1 ready after reset", int'(ready), 1);
        bus_read(8'h00, v);
        check("R1 array word after reset", v, 8'hA5);
        // R11 read strobe low
        addr = 8'h00;
        #1;
        check("R11 rdata with rd_en low", rdata, 0);

        for (int i = 0; i < NVEC; i++) begin
            bus_write(8'h00, VECS[i].d1);
            if (VECS[i].two) bus_write(VECS[i].a2, VECS[i].d2);
            bus_read(VECS[i].ra, v);
            check($sformatf("R%0d table row %0d", VECS[i].req, i), v, VECS[i].exp);
        end

        // R4 lock block 2
        bus_write(8'h00, 8'h77);
        bus_write(8'hBE, 8'hD0);
        bus_read(8'h80, v);
        check("R8 busy read gives status", v, 8'h00);
        count_busy(n);
        check("R4 lock program busy cycles", n, OPC);
        bus_read(8'h10, v);
        check("R11 status mode after lock program", v, 8'h80);
        bus_write(8'h00, 8'h71);
        bus_write(8'hBE, 8'h00);
        bus_read(8'h00, v);
        check("R4 block 2 lock bit cleared", v, 8'h00);

        // set error bits, then erase-all with block 2 locked
        bus_write(8'h00, 8'hA7);
        bus_write(8'h00, 8'h00);
        bus_write(8'h00, 8'hA7);
        bus_write(8'h00, 8'hD0);
        bus_write(8'h00, 8'h50);   // ignored while busy
        bus_write(8'h00, 8'hFF);   // ignored while busy
        count_busy(n);
        check("R3 erase busy with one locked block", n + 2, 3 * OPC + 1);
        bus_read(8'h00, v);
        check("R8 writes during busy ignored", v, 8'hB0);
        bus_write(8'h00, 8'hFF);
        bus_read(8'h00, v);
        check("R2 block 0 erased", v, 8'hFF);
        bus_read(8'h7F, v);
        check("R2 block 1 erased", v, 8'hFF);
        bus_read(8'h80, v);
        check("R3 locked block 2 kept", v, 8'h25);
        bus_read(8'hFF, v);
        check("R2 block 3 erased", v, 8'hFF);
        bus_write(8'h00, 8'h71);
        bus_write(8'h3E, 8'h00);
        bus_read(8'h00, v);
        check("R5 block 0 lock bit after erase", v, 8'h40);

        // full erase with every block unlocked
        do_reset();
        bus_write(8'h00, 8'hA7);
        bus_write(8'h00, 8'hD0);
        count_busy(n);
        check("R2 erase-all busy cycles", n, NBLK * OPC);
        bus_read(8'h40, v);
        check("R11 status after erase-all", v, 8'h80);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule